// File: doc/BRIEF.md
# Fault-Tolerant FSM State Register

This block holds the current state of a finite state machine with `N_STATES` states and checks that state on every cycle. Next-state logic outside the block presents a state index. On each rising clock edge the block encodes that index and stores it. A compile-time parameter chooses the storage code:

- a plain unsigned index;
- a one-flop-per-state word;
- the index extended with single-error-correcting, double-error-detecting check bits.

The stored word is decoded continuously into `cur_state`. A word with one flipped bit is repaired on the fly, and the same cycle shows a `err_corr` pulse. A word that cannot be repaired sets `err_fatal`, which stays set until reset. While it is set, `cur_state` is held at 0. The machine's own transition logic reads `cur_state` and feeds back `next_idx`, so a repaired value reaches the register again at the next edge.

For verification, the inputs `inj_en` and `inj_mask` let a fault be planted. On an edge where `inj_en` is high, the stored word is XORed with the mask and no new state is loaded.

Top module: `ftsr_state_reg`

## Requirements
- R1: When `rst_n` goes low, the block clears at once, with no clock edge needed: `cur_state` reads 0 and `err_corr` and `err_fatal` read 0.
- R2: With `inj_en` low, a rising edge stores `next_idx`, and `cur_state` shows that value from the following cycle.
- R3: A `next_idx` of `N_STATES` or more stores state 0.
- R4: In binary mode, the word has `IW = ceil(log2 N_STATES)` bits and holds the index as an unsigned number. A stored value of `N_STATES` or more is uncorrectable.
- R5: In one-hot mode, the word has `N_STATES` bits, and bit i set alone means state i. A word with zero bits set, or with two or more bits set, is uncorrectable.
- R6: In Hamming mode, the word has `IW + R + 1` bits, where R is the smallest value with 2^R >= IW + R + 1. For 5 states this is 7 bits. The bits are laid out as follows:
  - Bit 0 makes the whole word even parity.
  - Bits 1 to IW+R follow Hamming positions. Bit 2^i is even parity over every position whose number has bit i set.
  - The index bits fill the remaining positions in ascending order, least significant bit first.
- R7: In Hamming mode, a single flipped bit at any position has three effects in the cycle the faulty word is held: `cur_state` shows the original state, `err_corr` is high, and `err_fatal` stays low.
- R8: `err_corr` lasts one cycle. The next edge without injection writes a fresh code word, and `err_corr` drops.
- R9: In Hamming mode, any two flipped bits raise `err_fatal`.
- R10: `err_fatal` stays high through later loads until reset. While it is high, `cur_state` reads 0.
- R11: On an edge with `inj_en` high, the stored word becomes the old word XOR `inj_mask`, and `next_idx` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_idx | input | IW | Next state index from the transition logic |
| inj_en | input | 1 | Apply `inj_mask` to the stored word instead of loading |
| inj_mask | input | SW | XOR mask for fault planting; SW is the stored word width |
| cur_state | output | IW | Decoded, corrected current state |
| err_corr | output | 1 | A single-bit error is being corrected this cycle |
| err_fatal | output | 1 | Sticky uncorrectable-error flag |

## Verification
The load assertions assume that corruption reaches the stored word only through `inj_en`. For that reason they exclude injection edges and accept a cleared state whenever `err_fatal` is set. The pulse assertion likewise assumes that no new fault is planted on the edge that follows a correction. The stimulus keeps within both assumptions in three ways:
- It raises `inj_en` for a single edge at a time.
- It always reloads a valid index afterwards.
- It issues a reset after every case that leaves the sticky flag set.

The sweeps cover every state of a five-state machine under every single-bit flip, every two-bit flip, and every cross-code mask.

// File: rtl/ftsr_pkg.sv
package ftsr_pkg;

   typedef enum logic [1:0] {
      ENC_BIN     = 2'd0,
      ENC_ONEHOT  = 2'd1,
      ENC_HAMMING = 2'd2
   } enc_e;

   function automatic int idx_width(int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic int ham_checks(int m);
      int r;
      r = 1;
      while ((1 << r) < (m + r + 1)) r++;
      return r;
   endfunction

   function automatic int word_width(enc_e e, int n);
      case (e)
         ENC_ONEHOT:  return n;
         ENC_HAMMING: return idx_width(n) + ham_checks(idx_width(n)) + 1;
         default:     return idx_width(n);
      endcase
   endfunction

endpackage

// File: rtl/ftsr_encoder.sv
module ftsr_encoder #(
   parameter int             N_STATES = 5,
   parameter ftsr_pkg::enc_e ENC      = ftsr_pkg::ENC_HAMMING,
   parameter int             IW       = ftsr_pkg::idx_width(N_STATES),
   parameter int             SW       = ftsr_pkg::word_width(ENC, N_STATES)
) (
   input  logic [IW-1:0] idx_i,
   output logic [SW-1:0] word_o
);

   if (ENC == ftsr_pkg::ENC_ONEHOT) begin : g_onehot
      always_comb begin
         word_o        = '0;
         word_o[idx_i] = 1'b1;
      end
   end else if (ENC == ftsr_pkg::ENC_HAMMING) begin : g_ham
      localparam int R  = ftsr_pkg::ham_checks(IW);
      localparam int HN = IW + R;
      always_comb begin
         int k;
         word_o = '0;
         k      = 0;
         // data bits go to the positions that are not powers of two
         for (int p = 1; p <= HN; p++) begin
            if ((p & (p - 1)) != 0) begin
               word_o[p] = idx_i[k];
               k++;
            end
         end
         // check bit 2^i covers every position with bit i set
         for (int i = 0; i < R; i++) begin
            for (int p = 1; p <= HN; p++) begin
               if ((((p >> i) & 1) == 1) && (p != (1 << i)))
                  word_o[1 << i] = word_o[1 << i] ^ word_o[p];
            end
         end
         word_o[0] = ^word_o[HN:1];
      end
   end else begin : g_bin
      assign word_o = idx_i;
   end

endmodule

// File: rtl/ftsr_decoder.sv
module ftsr_decoder #(
   parameter int             N_STATES = 5,
   parameter ftsr_pkg::enc_e ENC      = ftsr_pkg::ENC_HAMMING,
   parameter int             IW       = ftsr_pkg::idx_width(N_STATES),
   parameter int             SW       = ftsr_pkg::word_width(ENC, N_STATES)
) (
   input  logic [SW-1:0] word_i,
   output logic [IW-1:0] idx_o,
   output logic          corr_o,
   output logic          unc_o
);

   if (ENC == ftsr_pkg::ENC_ONEHOT) begin : g_onehot
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < SW; i++) begin
            if (word_i[i]) idx_o = IW'(i);
         end
         corr_o = 1'b0;
         unc_o  = ($countones(word_i) != 1);
      end
   end else if (ENC == ftsr_pkg::ENC_HAMMING) begin : g_ham
      localparam int R  = ftsr_pkg::ham_checks(IW);
      localparam int HN = IW + R;
      logic [R-1:0] syn;
      logic         par;
      logic         single;
      logic         dbl;
      always_comb begin
         int k;
         syn = '0;
         for (int p = 1; p <= HN; p++) begin
            if (word_i[p]) syn = syn ^ R'(p);
         end
         par    = ^word_i;
         single = 1'b0;
         dbl    = 1'b0;
         if (par) begin
            // odd parity: one flip, located by the syndrome (0 = bit 0)
            if (int'(syn) <= HN) single = 1'b1;
            else                 dbl    = 1'b1;
         end else if (syn != '0) begin
            dbl = 1'b1;
         end
         idx_o = '0;
         k     = 0;
         for (int p = 1; p <= HN; p++) begin
            if ((p & (p - 1)) != 0) begin
               idx_o[k] = word_i[p] ^ (single && (int'(syn) == p));
               k++;
            end
         end
         unc_o  = dbl || (int'(idx_o) >= N_STATES);
         corr_o = single && !unc_o;
      end
   end else begin : g_bin
      assign idx_o  = word_i;
      assign corr_o = 1'b0;
      assign unc_o  = (int'(word_i) >= N_STATES);
   end

endmodule

// File: rtl/ftsr_state_reg.sv
module ftsr_state_reg #(
   parameter int             N_STATES = 5,
   parameter ftsr_pkg::enc_e ENC      = ftsr_pkg::ENC_HAMMING,
   localparam int            IW       = ftsr_pkg::idx_width(N_STATES),
   localparam int            SW       = ftsr_pkg::word_width(ENC, N_STATES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] next_idx,
   input  logic          inj_en,
   input  logic [SW-1:0] inj_mask,
   output logic [IW-1:0] cur_state,
   output logic          err_corr,
   output logic          err_fatal
);

   // code word of state 0: a single set bit in one-hot, all zero otherwise
   localparam logic [SW-1:0] RST_WORD =
      (ENC == ftsr_pkg::ENC_ONEHOT) ? SW'(1) : '0;

   initial begin
      assert (N_STATES >= 2)
         else $error("ftsr_state_reg: N_STATES must be at least 2");
   end

   logic [IW-1:0] safe_idx;
   logic [SW-1:0] enc_word;
   logic [SW-1:0] word_q;
   logic [IW-1:0] dec_idx;
   logic          dec_corr;
   logic          dec_unc;
   logic          fatal_q;

   assign safe_idx = (int'(next_idx) < N_STATES) ? next_idx : '0;

   ftsr_encoder #(
      .N_STATES (N_STATES),
      .ENC      (ENC),
      .IW       (IW),
      .SW       (SW)
   ) u_enc (
      .idx_i  (safe_idx),
      .word_o (enc_word)
   );

   ftsr_decoder #(
      .N_STATES (N_STATES),
      .ENC      (ENC),
      .IW       (IW),
      .SW       (SW)
   ) u_dec (
      .word_i (word_q),
      .idx_o  (dec_idx),
      .corr_o (dec_corr),
      .unc_o  (dec_unc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q  <= RST_WORD;
         fatal_q <= 1'b0;
      end else begin
         word_q <= inj_en ? (word_q ^ inj_mask) : enc_word;
         if (dec_unc) fatal_q <= 1'b1;
      end
   end

   assign err_fatal = fatal_q | dec_unc;
   assign err_corr  = dec_corr;
   assign cur_state = err_fatal ? '0 : dec_idx;

endmodule

// File: rtl/ftsr_state_reg_chk.sv
module ftsr_state_reg_chk #(
   parameter int N_STATES = 5,
   parameter int IW       = ftsr_pkg::idx_width(N_STATES)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [IW-1:0] next_idx,
   input logic          inj_en,
   input logic [IW-1:0] cur_state,
   input logic          err_corr,
   input logic          err_fatal
);

   AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_en && int'(next_idx) < N_STATES) |=> (err_fatal || cur_state == $past(next_idx))); // R2

   AST_LOAD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_en && int'(next_idx) >= N_STATES) |=> (cur_state == '0)); // R3

   AST_CORR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_corr && !inj_en) |=> !err_corr); // R8

   AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_fatal |=> err_fatal); // R10

   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cur_state) < N_STATES); // R4

endmodule

bind ftsr_state_reg ftsr_state_reg_chk #(
   .N_STATES (N_STATES),
   .IW       (IW)
) u_chk (.*);

// File: tb/ftsr_state_reg_bench.sv
module ftsr_state_reg_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] next_idx = '0;
   logic       inj_en = 1'b0;
   logic [6:0] m_ham = '0;
   logic [2:0] m_bin = '0;
   logic [4:0] m_oh  = '0;

   logic [2:0] cs_ham, cs_bin, cs_oh;
   logic       co_ham, co_bin, co_oh;
   logic       fa_ham, fa_bin, fa_oh;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ftsr_state_reg #(.N_STATES(N), .ENC(ftsr_pkg::ENC_HAMMING)) u_ftsr_state_reg (
      .clk(clk), .rst_n(rst_n), .next_idx(next_idx), .inj_en(inj_en), .inj_mask(m_ham),
      .cur_state(cs_ham), .err_corr(co_ham), .err_fatal(fa_ham));

   ftsr_state_reg #(.N_STATES(N), .ENC(ftsr_pkg::ENC_BIN)) u_ftsr_state_reg_bin (
      .clk(clk), .rst_n(rst_n), .next_idx(next_idx), .inj_en(inj_en), .inj_mask(m_bin),
      .cur_state(cs_bin), .err_corr(co_bin), .err_fatal(fa_bin));

   ftsr_state_reg #(.N_STATES(N), .ENC(ftsr_pkg::ENC_ONEHOT)) u_ftsr_state_reg_oh (
      .clk(clk), .rst_n(rst_n), .next_idx(next_idx), .inj_en(inj_en), .inj_mask(m_oh),
      .cur_state(cs_oh), .err_corr(co_oh), .err_fatal(fa_oh));

   // Hamming code word for 3 index bits, per R6: data at 3,5,6; checks at 1,2,4; parity at 0
   function automatic logic [6:0] henc(int d);
      logic [6:0] w;
      w    = '0;
      w[3] = d[0];
      w[5] = d[1];
      w[6] = d[2];
      w[1] = w[3] ^ w[5];
      w[2] = w[3] ^ w[6];
      w[4] = w[5] ^ w[6];
      w[0] = ^w[6:1];
      return w;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 ham state", int'(cs_ham), 0);
      chk("R1 bin state", int'(cs_bin), 0);
      chk("R1 oh state", int'(cs_oh), 0);
      chk("R1 flags", int'({co_ham, fa_ham, co_bin, fa_bin, co_oh, fa_oh}), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load(int s);
      next_idx = 3'(s);
      inj_en   = 1'b0;
      tick();
   endtask

   task automatic inject(logic [6:0] mh, logic [2:0] mb, logic [4:0] mo);
      m_ham  = mh;
      m_bin  = mb;
      m_oh   = mo;
      inj_en = 1'b1;
      tick();
      inj_en = 1'b0;
      m_ham  = '0;
      m_bin  = '0;
      m_oh   = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      load(3);
      do_reset();   // asynchronous clear from a non-zero state

      // R2, R3: load every index value, valid and out of range
      for (int i = 0; i < 8; i++) begin
         load(i);
         chk("R2/R3 ham load", int'(cs_ham), (i < N) ? i : 0);
         chk("R2/R3 bin load", int'(cs_bin), (i < N) ? i : 0);
         chk("R2/R3 oh load", int'(cs_oh), (i < N) ? i : 0);
      end

      // R4, R5, R6, R11: a mask mapping code(a) onto code(b) lands in state b
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            load(a);
            inject(henc(a) ^ henc(b), 3'(a ^ b), 5'((1 << a) ^ (1 << b)));
            chk("R6 ham layout", int'(cs_ham), b);
            chk("R6 ham no flags", int'({co_ham, fa_ham}), 0);
            chk("R4 bin layout", int'(cs_bin), b);
            chk("R5 oh layout", int'(cs_oh), b);
            chk("R11 no flags", int'({fa_bin, fa_oh}), 0);
         end
      end

      // R7, R8: every single flip is corrected, pulse lasts one cycle
      for (int s = 0; s < N; s++) begin
         for (int bt = 0; bt < 7; bt++) begin
            load(s);
            inject(7'(1 << bt), '0, '0);
            chk("R7 corrected state", int'(cs_ham), s);
            chk("R7 corr pulse", int'(co_ham), 1);
            chk("R7 no fatal", int'(fa_ham), 0);
            load(s);
            chk("R8 pulse cleared", int'(co_ham), 0);
         end
      end

      // R9, R10: every double flip is fatal and sticky
      for (int s = 0; s < N; s++) begin
         for (int b1 = 0; b1 < 7; b1++) begin
            for (int b2 = b1 + 1; b2 < 7; b2++) begin
               do_reset();
               load(s);
               inject(7'((1 << b1) | (1 << b2)), '0, '0);
               chk("R9 double fatal", int'(fa_ham), 1);
               chk("R10 state zero", int'(cs_ham), 0);
               load(2);
               chk("R10 sticky", int'(fa_ham), 1);
               chk("R10 held zero", int'(cs_ham), 0);
            end
         end
      end

      // R5: any single flip of a one-hot word is uncorrectable
      for (int s = 0; s < N; s++) begin
         for (int bt = 0; bt < N; bt++) begin
            do_reset();
            load(s);
            inject('0, '0, 5'(1 << bt));
            chk("R5 oh fatal", int'(fa_oh), 1);
            chk("R5 oh zero", int'(cs_oh), 0);
            chk("R5 oh no corr", int'(co_oh), 0);
         end
      end

      // R4: binary flips into a valid code are silent, out of range is fatal
      for (int s = 0; s < N; s++) begin
         for (int bt = 0; bt < 3; bt++) begin
            int v;
            v = s ^ (1 << bt);
            do_reset();
            load(s);
            inject('0, 3'(1 << bt), '0);
            chk("R4 bin fatal", int'(fa_bin), (v >= N) ? 1 : 0);
            chk("R4 bin state", int'(cs_bin), (v >= N) ? 0 : v);
         end
      end

      do_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule